// File: doc/BRIEF.md
# Edge/Level Interrupt Pin Request Engine

This block sits between a set of interrupt input lines and a single delivery port toward the processors. Each pin has a routing entry that holds a vector, a destination, a delivery mode, a destination-addressing flag, an input polarity, a trigger mode and a mask. The engine brings every line into the clock domain and applies the polarity. It records a pending bit per pin and decides when an event becomes a delivery request carrying the entry's fields.

Level-triggered pins hold a remote-pending flag. It is set when a delivery goes out and cleared by an end-of-interrupt (EOI) notification whose vector matches and whose trigger mode is level. While the flag is set, the pin cannot be delivered again. Edge-triggered pins deliver once for each inactive-to-active transition. Any event that cannot become a separate delivery is reported as coalesced on a per-pin pulse output. Each EOI also raises an acknowledge pulse for every pin whose vector matches.

Routing entries are written as two 32-bit halves through a simple write port. The delivery port uses a valid/ready handshake. While it is stalled, requests wait and are served lowest pin first, one per cycle.

Top module: `irq_pin_engine`

## Requirements
- R1: The effective level of a pin is its synchronised line XOR the polarity bit (low half, bit 13; 1 means active low). Only a change of the effective level from 0 to 1 counts as a new assertion.
- R2: An edge-triggered pin (low half bit 15 = 0) produces exactly one delivery per 0-to-1 change of its effective level, however long the level then stays high.
- R3: If an edge-triggered pin sees a new 0-to-1 change while its previous request is still waiting for the port, the pin's coalesced output pulses for one cycle, and only one delivery results.
- R4: A level-triggered pin (bit 15 = 1) whose effective level rises while its remote-pending flag is clear is delivered, and that delivery sets the flag.
- R5: A level-triggered pin whose effective level rises while its remote-pending flag is set is not delivered; its coalesced output pulses once.
- R6: An entry with its mask bit (low half bit 16) set produces no delivery and no coalesced pulse. Setting the mask withdraws a request that is still waiting.
- R7: An EOI with level trigger mode clears the remote-pending flag of every entry whose vector matches. A matching unmasked level entry whose effective level is still high is delivered again.
- R8: An EOI with edge trigger mode leaves remote-pending flags unchanged and causes no delivery. In both modes, one cycle after the EOI, the acknowledge output has a bit set for every pin whose vector matches.
- R9: A low-half write clears that pin's remote-pending flag. If the written entry is level-triggered, unmasked and its effective level is high, the pin is delivered without a new line change.
- R10: Waiting requests are offered lowest pin index first, one per cycle. While ready is low, the port holds valid.
- R11: A delivery carries the entry's fields: vector from low bits 7:0, delivery mode from bits 10:8, destination-addressing flag from bit 11, trigger mode from bit 15, and destination from high-half bits 31:24. It also carries the pin index.
- R12: After reset every entry is masked and valid, coalesced and acknowledge outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_line | input | NPINS | Raw interrupt input lines |
| cfg_we | input | 1 | Routing entry write strobe |
| cfg_pin | input | IDXW | Pin whose entry is written |
| cfg_hi | input | 1 | 1 selects the high half, 0 the low half |
| cfg_data | input | 32 | Write data for the selected half |
| eoi_valid | input | 1 | End-of-interrupt notification strobe |
| eoi_vector | input | 8 | Vector of the EOI |
| eoi_level | input | 1 | EOI trigger mode, 1 = level |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Delivery port accepts the request |
| dlv_pin | output | IDXW | Pin index of the request |
| dlv_vector | output | 8 | Vector of the request |
| dlv_dest | output | 8 | Destination of the request |
| dlv_dmode | output | 3 | Delivery mode of the request |
| dlv_logical | output | 1 | Destination-addressing flag |
| dlv_level | output | 1 | Trigger mode of the request, 1 = level |
| coal | output | NPINS | One-cycle coalesced pulse per pin |
| ack | output | NPINS | One-cycle acknowledge pulse per pin matching an EOI |

## Verification
The bench builds the engine with six pins and three synchroniser stages. Six pins is not a power of two, so the pin index field has unused codes. Three stages push each line change four clocks away from its delivery, which leaves room to fall and rise again while a request is stalled. With three edge pins released together behind a held ready, the ordering and stall rules can be seen. Pairing a level pin with EOIs of both modes, and a repeated low-half write, separates the flag-clearing paths from the re-delivery paths.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;

   localparam int VEC_W   = 8;
   localparam int DEST_W  = 8;
   localparam int DMODE_W = 3;
   localparam int WORD_W  = 32;

   // low-half field positions
   localparam int LO_VEC_LSB   = 0;
   localparam int LO_DMODE_LSB = 8;
   localparam int LO_LOGICAL   = 11;
   localparam int LO_POL       = 13;
   localparam int LO_LEVEL     = 15;
   localparam int LO_MASK      = 16;
   // high-half field position
   localparam int HI_DEST_LSB  = 24;

   typedef struct packed {
      logic [DEST_W-1:0]  dest;
      logic               mask;
      logic               level;
      logic               pol;
      logic               logical;
      logic [DMODE_W-1:0] dmode;
      logic [VEC_W-1:0]   vec;
   } route_t;

   localparam route_t ROUTE_RESET = '{dest: '0, mask: 1'b1, level: 1'b0,
                                      pol: 1'b0, logical: 1'b0,
                                      dmode: '0, vec: '0};

endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 0) begin : g_bad_stages
      initial $fatal(1, "irq_in_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] st [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
         end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
         end
      end
      assign q = st[STAGES-1];
   end

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
   import irq_pin_pkg::*;
#(
   parameter int NPINS = 8,
   parameter int IDXW  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [IDXW-1:0]         pin,
   input  logic                    hi,
   input  logic [WORD_W-1:0]       data,
   output route_t [NPINS-1:0]      ents,
   output logic   [NPINS-1:0]      wr_lo
);

   logic wr_unused;
   assign wr_unused = ^{data[12], data[14], data[23:17]};

   for (genvar g = 0; g < NPINS; g++) begin : g_ent
      route_t r;
      logic   sel;
      assign sel = we && (pin == IDXW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r <= ROUTE_RESET;
         end else if (sel) begin
            if (hi) begin
               r.dest <= data[HI_DEST_LSB +: DEST_W];
            end else begin
               r.vec     <= data[LO_VEC_LSB +: VEC_W];
               r.dmode   <= data[LO_DMODE_LSB +: DMODE_W];
               r.logical <= data[LO_LOGICAL];
               r.pol     <= data[LO_POL];
               r.level   <= data[LO_LEVEL];
               r.mask    <= data[LO_MASK];
            end
         end
      end

      assign ents[g]  = r;
      assign wr_lo[g] = sel & ~hi;
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N    = 8,
   parameter int IDXW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    req,
   output logic [N-1:0]    gnt,
   output logic [IDXW-1:0] idx,
   output logic            any
);

   always_comb begin
      gnt = '0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt     = '0;
            gnt[i]  = 1'b1;
            idx     = IDXW'(i);
         end
      end
      any = |req;
   end

   assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt) && (any == (gnt != '0)));

endmodule

// File: rtl/irq_pin_cell.sv
module irq_pin_cell
   import irq_pin_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line,
   input  route_t           ent,
   input  logic             wr_lo,
   input  logic             gnt,
   input  logic             eoi_valid,
   input  logic [VEC_W-1:0] eoi_vector,
   input  logic             eoi_level,
   output logic             need,
   output logic             remote,
   output logic             coal,
   output logic             ack
);

   logic pending, wr_lo_d;
   logic eff, rise, edge_ev, lvl_ev, need_hold, eoi_hit;
   logic eoi_re, wr_re, set_req, coal_n;

   always_comb begin
      eff       = line ^ ent.pol;
      rise      = eff & ~pending;
      edge_ev   = rise & ~ent.level;
      lvl_ev    = rise & ent.level;
      need_hold = need & ~gnt;
      eoi_hit   = eoi_valid && (ent.vec == eoi_vector);
      eoi_re    = eoi_hit & eoi_level & ent.level & eff;
      wr_re     = wr_lo_d & ent.level & eff;
      set_req   = edge_ev | (lvl_ev & ~remote & ~need) | eoi_re | wr_re;
      coal_n    = ~ent.mask & ((edge_ev & need_hold) | (lvl_ev & (remote | need)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         wr_lo_d <= 1'b0;
         need    <= 1'b0;
         remote  <= 1'b0;
         coal    <= 1'b0;
         ack     <= 1'b0;
      end else begin
         pending <= eff;
         wr_lo_d <= wr_lo;
         need    <= (need_hold | set_req) & ~ent.mask;
         remote  <= (remote & ~(eoi_hit & eoi_level) & ~wr_lo) | (gnt & ent.level);
         coal    <= coal_n;
         ack     <= eoi_hit;
      end
   end

   assert_remote_from_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(remote) |-> $past(gnt && ent.level));

   assert_edge_eoi_keeps_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_hit && !eoi_level && !wr_lo && !gnt) |=> $stable(remote));

   assert_mask_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (need && ent.mask) |=> !need);

   assert_edge_needs_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(need) && $past(!ent.level)) |-> $past(eff && !pending));

endmodule

// File: rtl/irq_pin_engine.sv
module irq_pin_engine
   import irq_pin_pkg::*;
#(
   parameter int NPINS       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int IDXW       = (NPINS > 1) ? $clog2(NPINS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NPINS-1:0]     irq_line,
   input  logic                 cfg_we,
   input  logic [IDXW-1:0]      cfg_pin,
   input  logic                 cfg_hi,
   input  logic [WORD_W-1:0]    cfg_data,
   input  logic                 eoi_valid,
   input  logic [VEC_W-1:0]     eoi_vector,
   input  logic                 eoi_level,
   output logic                 dlv_valid,
   input  logic                 dlv_ready,
   output logic [IDXW-1:0]      dlv_pin,
   output logic [VEC_W-1:0]     dlv_vector,
   output logic [DEST_W-1:0]    dlv_dest,
   output logic [DMODE_W-1:0]   dlv_dmode,
   output logic                 dlv_logical,
   output logic                 dlv_level,
   output logic [NPINS-1:0]     coal,
   output logic [NPINS-1:0]     ack
);

   if (NPINS < 1 || NPINS > 64) begin : g_bad_npins
      initial $fatal(1, "irq_pin_engine: NPINS must be 1..64");
   end

   logic   [NPINS-1:0] line_s, need, remote, req, gnt, gnt_fire, wr_lo;
   route_t [NPINS-1:0] ents;
   route_t             sel;
   logic               fire;

   irq_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_line), .q(line_s));

   irq_route_table #(.NPINS(NPINS), .IDXW(IDXW)) i_table (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .pin(cfg_pin), .hi(cfg_hi),
      .data(cfg_data), .ents(ents), .wr_lo(wr_lo));

   for (genvar g = 0; g < NPINS; g++) begin : g_pin
      assign req[g] = need[g] & ~ents[g].mask;

      irq_pin_cell i_cell (
         .clk(clk), .rst_n(rst_n), .line(line_s[g]), .ent(ents[g]),
         .wr_lo(wr_lo[g]), .gnt(gnt_fire[g]),
         .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
         .need(need[g]), .remote(remote[g]), .coal(coal[g]), .ack(ack[g]));
   end

   irq_prio_pick #(.N(NPINS), .IDXW(IDXW)) i_pick (
      .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .idx(dlv_pin), .any(dlv_valid));

   assign fire     = dlv_valid & dlv_ready;
   assign gnt_fire = gnt & {NPINS{fire}};

   always_comb begin
      sel = '0;
      for (int i = 0; i < NPINS; i++) begin
         if (gnt[i]) sel = sel | ents[i];
      end
   end

   assign dlv_vector  = sel.vec;
   assign dlv_dest    = sel.dest;
   assign dlv_dmode   = sel.dmode;
   assign dlv_logical = sel.logical;
   assign dlv_level   = sel.level;

   assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid && !dlv_ready && !cfg_we) |=> dlv_valid);

   assert_flag_only_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && dlv_level) |=> remote[$past(dlv_pin)]);

endmodule

// File: tb/test_irq_pin_engine.sv
module test_irq_pin_engine;

   localparam int PERIOD = 10;
   localparam int NP     = 6;
   localparam int SYNC   = 3;
   localparam int IW     = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] irq_line = '0;
   logic          cfg_we = 1'b0;
   logic [IW-1:0] cfg_pin = '0;
   logic          cfg_hi = 1'b0;
   logic [31:0]   cfg_data = '0;
   logic          eoi_valid = 1'b0;
   logic [7:0]    eoi_vector = '0;
   logic          eoi_level = 1'b0;
   logic          dlv_valid;
   logic          dlv_ready = 1'b1;
   logic [IW-1:0] dlv_pin;
   logic [7:0]    dlv_vector, dlv_dest;
   logic [2:0]    dlv_dmode;
   logic          dlv_logical, dlv_level;
   logic [NP-1:0] coal, ack;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int coal_cnt [NP];
   logic [NP-1:0] ack_seen = '0;
   logic [23:0] exp_q [$];

   always #(PERIOD/2) clk = ~clk;

   irq_pin_engine #(.NPINS(NP), .SYNC_STAGES(SYNC)) i_irq_pin_engine (
      .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .cfg_we(cfg_we),
      .cfg_pin(cfg_pin), .cfg_hi(cfg_hi), .cfg_data(cfg_data),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
      .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_pin(dlv_pin),
      .dlv_vector(dlv_vector), .dlv_dest(dlv_dest), .dlv_dmode(dlv_dmode),
      .dlv_logical(dlv_logical), .dlv_level(dlv_level), .coal(coal), .ack(ack));

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every accepted delivery
   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < NP; i++) if (coal[i]) coal_cnt[i]++;
         ack_seen = ack_seen | ack;
         if (dlv_valid && dlv_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R6 unexpected delivery: actual pin %0d vector %0h expected none",
                        dlv_pin, dlv_vector);
            end else begin
               logic [23:0] e, a;
               e = exp_q.pop_front();
               a = {dlv_pin, dlv_vector, dlv_dest, dlv_dmode, dlv_logical, dlv_level};
               if (a !== e) begin
                  errors++;
                  $display("FAIL R11 delivery fields: actual %0h expected %0h", a, e);
               end
            end
         end
      end
   end

   function automatic logic [31:0] lo_word(input logic [7:0] vec, input logic [2:0] dm,
                                           input logic lg, input logic pol,
                                           input logic lvl, input logic msk);
      return {15'b0, msk, lvl, 1'b0, pol, 1'b0, lg, dm, vec};
   endfunction

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic settle(input int n);
      repeat (n) step();
   endtask

   task automatic wr(input int pin, input logic hi, input logic [31:0] d);
      cfg_we = 1'b1; cfg_pin = IW'(pin); cfg_hi = hi; cfg_data = d;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic expect_dlv(input int pin, input logic [7:0] vec, input logic [7:0] dest,
                             input logic [2:0] dm, input logic lg, input logic lvl);
      exp_q.push_back({IW'(pin), vec, dest, dm, lg, lvl});
   endtask

   task automatic eoi(input logic [7:0] vec, input logic lvl);
      eoi_valid = 1'b1; eoi_vector = vec; eoi_level = lvl;
      step();
      eoi_valid = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < NP; i++) coal_cnt[i] = 0;
      settle(5);
      rst_n = 1'b1;
      step();
      // R12: reset state
      check("R12", "valid after reset", 32'(dlv_valid), 0);
      check("R12", "coal after reset", 32'(coal), 0);
      check("R12", "ack after reset", 32'(ack), 0);

      // R6: pin 4 still masked from reset
      irq_line[4] = 1'b1;
      settle(12);
      check("R6", "masked pin valid", 32'(dlv_valid), 0);
      check("R6", "masked pin coal", 32'(coal_cnt[4]), 0);
      irq_line[4] = 1'b0;

      // R2/R11: edge pin 0
      wr(0, 1'b1, {8'h5A, 24'h0});
      wr(0, 1'b0, lo_word(8'h30, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0));
      expect_dlv(0, 8'h30, 8'h5A, 3'b001, 1'b1, 1'b0);
      irq_line[0] = 1'b1;
      settle(30);
      check("R2", "edge single delivery", 32'(exp_q.size()), 0);
      irq_line[0] = 1'b0;
      settle(8);
      expect_dlv(0, 8'h30, 8'h5A, 3'b001, 1'b1, 1'b0);
      irq_line[0] = 1'b1;
      settle(12);
      check("R2", "edge second rise", 32'(exp_q.size()), 0);

      // R1: active-low pin 1
      irq_line[1] = 1'b1;
      settle(8);
      wr(1, 1'b1, {8'h11, 24'h0});
      wr(1, 1'b0, lo_word(8'h41, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0));
      settle(10);
      check("R1", "inactive high line", 32'(dlv_valid), 0);
      expect_dlv(1, 8'h41, 8'h11, 3'b000, 1'b0, 1'b0);
      irq_line[1] = 1'b0;
      settle(12);
      check("R1", "active low delivery", 32'(exp_q.size()), 0);

      // R4/R5: level pin 2
      wr(2, 1'b1, {8'h22, 24'h0});
      wr(2, 1'b0, lo_word(8'h52, 3'b010, 1'b0, 1'b0, 1'b1, 1'b0));
      expect_dlv(2, 8'h52, 8'h22, 3'b010, 1'b0, 1'b1);
      irq_line[2] = 1'b1;
      settle(12);
      check("R4", "level delivery", 32'(exp_q.size()), 0);
      irq_line[2] = 1'b0;
      settle(8);
      irq_line[2] = 1'b1;
      settle(12);
      check("R5", "level coalesced count", 32'(coal_cnt[2]), 1);

      // R8: edge-mode EOI acknowledges, no re-delivery
      ack_seen = '0;
      eoi(8'h52, 1'b0);
      settle(10);
      check("R8", "edge eoi ack", 32'(ack_seen), 32'(6'b000100));
      check("R8", "edge eoi no delivery", 32'(exp_q.size()), 0);

      // R7: level-mode EOI with line still high redelivers
      expect_dlv(2, 8'h52, 8'h22, 3'b010, 1'b0, 1'b1);
      eoi(8'h52, 1'b1);
      settle(10);
      check("R7", "level eoi redelivery", 32'(exp_q.size()), 0);
      irq_line[2] = 1'b0;
      settle(8);
      eoi(8'h52, 1'b1);
      settle(10);
      check("R7", "eoi with line low", 32'(dlv_valid), 0);
      expect_dlv(2, 8'h52, 8'h22, 3'b010, 1'b0, 1'b1);
      irq_line[2] = 1'b1;
      settle(12);
      check("R7", "flag cleared then rise", 32'(exp_q.size()), 0);

      // R9: low-half rewrite clears flag and services held level
      expect_dlv(2, 8'h52, 8'h22, 3'b010, 1'b0, 1'b1);
      wr(2, 1'b0, lo_word(8'h52, 3'b010, 1'b0, 1'b0, 1'b1, 1'b0));
      settle(8);
      check("R9", "write reservice", 32'(exp_q.size()), 0);

      // R10/R3: ordering and stall
      for (int p = 3; p < 6; p++) begin
         wr(p, 1'b1, {8'(8'h70 + p), 24'h0});
         wr(p, 1'b0, lo_word(8'(8'h60 + p), 3'b100, 1'b0, 1'b0, 1'b0, 1'b0));
      end
      dlv_ready = 1'b0;
      irq_line[5] = 1'b1; irq_line[3] = 1'b1; irq_line[4] = 1'b1;
      settle(10);
      check("R10", "stall holds valid", 32'(dlv_valid), 1);
      check("R10", "lowest pin first", 32'(dlv_pin), 3);
      irq_line[4] = 1'b0;
      settle(8);
      irq_line[4] = 1'b1;
      settle(8);
      check("R3", "edge coalesced while waiting", 32'(coal_cnt[4]), 1);
      for (int p = 3; p < 6; p++)
         expect_dlv(p, 8'(8'h60 + p), 8'(8'h70 + p), 3'b100, 1'b0, 1'b0);
      dlv_ready = 1'b1;
      settle(10);
      check("R10", "ordered drain", 32'(exp_q.size()), 0);

      // R8: ack for every matching pin
      wr(5, 1'b0, lo_word(8'h63, 3'b100, 1'b0, 1'b0, 1'b0, 1'b0));
      ack_seen = '0;
      eoi(8'h63, 1'b0);
      settle(4);
      check("R8", "multi-pin ack", 32'(ack_seen), 32'(6'b101000));

      // R6: masking withdraws a waiting request
      dlv_ready = 1'b0;
      irq_line[0] = 1'b0;
      settle(8);
      irq_line[0] = 1'b1;
      settle(8);
      check("R6", "request waiting", 32'(dlv_valid), 1);
      wr(0, 1'b0, lo_word(8'h30, 3'b001, 1'b1, 1'b0, 1'b0, 1'b1));
      settle(2);
      dlv_ready = 1'b1;
      settle(8);
      check("R6", "masked request withdrawn", 32'(dlv_valid), 0);
      check("R6", "mask no coalesce", 32'(coal_cnt[0]), 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule